// File: doc/BRIEF.md
# Dual-Modulus Prescaler Feedback Divider

This block is a cycle-accurate digital model of a synthesizer feedback divider. A fast input clock stands in for the oscillator. A prescaler divides that clock by either P or P+1. Two counters then decide how many prescaler outputs use each modulus. The first counts A outputs at the larger modulus. The second counts B outputs in total for one output period. The result is one output pulse every N = P·B + A input cycles.

Software-side logic presents a prescaler mode, an A value and a B value, and strobes a load for one cycle. A legal setting is held as pending and moves into the active divider only when the current output period ends, so the output never shows a truncated or stretched period. An illegal setting is refused, the previous one is kept, and an error flag goes high.

Top module: `dmp_divider`

## Requirements
- R1: Prescaler mode code 0, 1, 2, 3 on `mode_i` selects a base modulus P of 8, 16, 32, 64 (larger modulus P+1).
- R2: With a legal active setting, `div_o` pulses once every P·B + A input cycles, where A is the 6-bit `a_i` value and B is the 13-bit `b_i` value.
- R3: Each `div_o` pulse is high for exactly one input cycle.
- R4: The boundary settings A = 0 (period P·B) and A = B (period (P+1)·B) produce the same period formula.
- R5: A load taken during a period does not change that period; the new setting governs the period that starts after the next pulse.
- R6: A load with B below 3 sets `cfg_err_o` and leaves the pending setting unchanged.
- R7: A load with B smaller than A sets `cfg_err_o` and leaves the pending setting unchanged.
- R8: A legal load clears `cfg_err_o` on the cycle after it is taken.
- R9: After reset `div_o` and `cfg_err_o` are low, and the divider runs with mode 0, A = 0, B = 3; the first pulse comes on the 24th input cycle after reset release.
- R10: When several loads are taken within one period, the last legal one is applied at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock standing in for the oscillator |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Prescaler modulus select |
| a_i | input | 6 | Swallow count A |
| b_i | input | 13 | Total count B |
| load_i | input | 1 | One-cycle strobe that captures mode_i, a_i, b_i |
| div_o | output | 1 | One-cycle pulse at the end of every output period |
| cfg_err_o | output | 1 | High after a refused load, low after a legal one |

## Verification
The assertions take for granted that the reset setting is itself legal. Given that, validation at load time means the active setting always satisfies B ≥ 3 and B ≥ A, and both counters stay inside their moduli whatever values are presented on the inputs. The stimulus holds `load_i` for a single cycle and places each load just after an observed pulse. This keeps the load edge off the period boundary, so the period under way still has a known length when a new setting arrives. Divide ratios are kept to a few thousand cycles so that three periods per setting fit comfortably in the run.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  localparam int MODE_W = 2;
  localparam int A_W    = 6;
  localparam int B_W    = 13;
  localparam int P_MIN  = 8;
  localparam int P_MAX  = P_MIN << ((1 << MODE_W) - 1);
  localparam int PC_W   = $clog2(P_MAX + 1);

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [A_W-1:0]    a;
    logic [B_W-1:0]    b;
  } div_cfg_t;
endpackage

// File: rtl/dmp_cfg.sv
module dmp_cfg
  import dmp_pkg::*;
#(
  parameter int B_MIN    = 3,
  parameter int RST_MODE = 0,
  parameter int RST_A    = 0,
  parameter int RST_B    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  input  logic              load_i,
  input  logic              period_end_i,
  output div_cfg_t          act_o,
  output logic              err_o
);
  localparam div_cfg_t RST_CFG = '{mode: MODE_W'(RST_MODE), a: A_W'(RST_A), b: B_W'(RST_B)};

  div_cfg_t pend_q, act_q;
  logic     err_q;
  logic     bad;

  // refuse B below floor or B below A
  assign bad = (b_i < B_W'(B_MIN)) || (b_i < {{(B_W-A_W){1'b0}}, a_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RST_CFG;
      act_q  <= RST_CFG;
      err_q  <= 1'b0;
    end else begin
      if (load_i) begin
        err_q <= bad;
        if (!bad) pend_q <= '{mode: mode_i, a: a_i, b: b_i};
      end
      if (period_end_i) act_q <= pend_q;
    end
  end

  assign act_o = act_q;
  assign err_o = err_q;

  AST_CFG_HOLD:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                     !period_end_i |=> $stable(act_q));                          // R5
  AST_BAD_KEEP:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (load_i && bad) |=> ($stable(pend_q) && err_o));            // R6
  AST_ACT_LEGAL:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (act_q.b >= B_W'(B_MIN)) && (act_q.b >= {{(B_W-A_W){1'b0}}, act_q.a})); // R7
endmodule

// File: rtl/dmp_presc.sv
module dmp_presc
  import dmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              hi_mod_i,
  output logic              tick_o
);
  logic [PC_W-1:0] cnt_q;
  logic [PC_W-1:0] base_p;
  logic [PC_W-1:0] last_cnt;

  assign base_p   = PC_W'(P_MIN) << mode_i;
  // P+1 modulus ends one count later than P
  assign last_cnt = hi_mod_i ? base_p : base_p - PC_W'(1);
  assign tick_o   = (cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PC_W'(1);
  end

  AST_PRESC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                     cnt_q <= base_p);                                            // R1
endmodule

// File: rtl/dmp_swallow.sv
module dmp_swallow
  import dmp_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           tick_i,
  output logic           hi_mod_o,
  output logic           end_o
);
  logic [B_W-1:0] cnt_q;

  assign hi_mod_o = cnt_q < {{(B_W-A_W){1'b0}}, a_i};
  assign end_o    = tick_i && (cnt_q == b_i - B_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (end_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + B_W'(1);
  end

  AST_SWALLOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                       cnt_q < b_i);                                              // R2
endmodule

// File: rtl/dmp_divider.sv
module dmp_divider
  import dmp_pkg::*;
#(
  parameter int B_MIN    = 3,
  parameter int RST_MODE = 0,
  parameter int RST_A    = 0,
  parameter int RST_B    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  input  logic              load_i,
  output logic              div_o,
  output logic              cfg_err_o
);
  div_cfg_t act;
  logic     tick, hi_mod, period_end;
  logic     div_q;

  dmp_cfg #(
    .B_MIN(B_MIN), .RST_MODE(RST_MODE), .RST_A(RST_A), .RST_B(RST_B)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .a_i(a_i), .b_i(b_i),
    .load_i(load_i), .period_end_i(period_end), .act_o(act), .err_o(cfg_err_o)
  );

  dmp_presc u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(act.mode),
    .hi_mod_i(hi_mod), .tick_o(tick)
  );

  dmp_swallow u_swallow (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(act.a), .b_i(act.b),
    .tick_i(tick), .hi_mod_o(hi_mod), .end_o(period_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= period_end;
  end

  assign div_o = div_q;

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
                     div_o |=> !div_o);                                           // R3
  AST_END_ONEHOT:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                     period_end |-> tick);                                        // R2
endmodule

// File: tb/tb_dmp_divider.sv
`timescale 1ns/1ps
module tb_dmp_divider;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [5:0]  a_i = '0;
  logic [12:0] b_i = '0;
  logic        load_i = 1'b0;
  logic        div_o, cfg_err_o;

  int total = 0;
  int bad = 0;
  int cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dmp_divider dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .a_i(a_i), .b_i(b_i),
    .load_i(load_i), .div_o(div_o), .cfg_err_o(cfg_err_o)
  );

  // mode, a, b, expected period
  localparam int VEC [8][4] = '{
    '{0,  5,    7,   61},
    '{1,  3,    4,   67},
    '{2, 10,   10,  330},
    '{3, 63,   63, 4095},
    '{3,  0,    3,  192},
    '{1, 16,   16,  272},
    '{0, 63, 1000, 8063},
    '{2,  0,    3,   96}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cnt++;
  endtask

  task automatic to_pulse(output int n);
    do tick(); while (!div_o);
    n = cnt;
    cnt = 0;
  endtask

  task automatic put(int m, int a, int b);
    mode_i = 2'(m); a_i = 6'(a); b_i = 13'(b); load_i = 1'b1;
    tick();
    load_i = 1'b0;
  endtask

  initial begin
    int n, prev;
    repeat (3) @(negedge clk);
    check("R9 div_o in reset", int'(div_o), 0);
    check("R9 cfg_err_o in reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    cnt = 0;
    to_pulse(n);
    check("R9 first period", n, 24);
    prev = 24;

    for (int i = 0; i < 8; i++) begin
      put(VEC[i][0], VEC[i][1], VEC[i][2]);
      check("R3 pulse width", int'(div_o), 0);
      to_pulse(n);
      check("R5 period under way", n, prev);
      to_pulse(n);
      if (VEC[i][1] == VEC[i][2] || VEC[i][1] == 0)
        check("R4 boundary period", n, VEC[i][3]);
      else
        check("R2 R1 period", n, VEC[i][3]);
      check("R8 err clear", int'(cfg_err_o), 0);
      prev = VEC[i][3];
    end

    // R6: B below floor refused
    put(0, 0, 2);
    check("R6 err set", int'(cfg_err_o), 1);
    to_pulse(n);
    to_pulse(n);
    check("R6 setting kept", n, 96);

    // R7: B smaller than A refused
    put(0, 9, 8);
    check("R7 err set", int'(cfg_err_o), 1);
    to_pulse(n);
    to_pulse(n);
    check("R7 setting kept", n, 96);

    // R10: last legal load in a period wins
    put(0, 0, 5);
    put(1, 2, 3);
    check("R8 err cleared", int'(cfg_err_o), 0);
    to_pulse(n);
    check("R5 period under way", n, 96);
    to_pulse(n);
    check("R10 last load wins", n, 50);

    // R6: refused load after a legal one keeps the legal one
    put(0, 1, 4);
    put(0, 0, 1);
    check("R6 err after refused", int'(cfg_err_o), 1);
    to_pulse(n);
    to_pulse(n);
    check("R6 legal pending kept", n, 33);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule